// File: doc/BRIEF.md
# Period and Pulse-Width Capture Timer

This block measures the timing of one external digital input against the system clock. A two-bit mode input chooses one of four measurements: the full period from one rising edge to the next, the full period from one falling edge to the next, the width of a high pulse, or the width of a low pulse. The counter advances only in cycles where the count-enable input `tick` is high. That input carries the selected internal or external clock source, already divided down elsewhere.

When a measurement completes, the running count is written into the capture register and the counter then restarts from zero. At the same time, a sticky end-of-measurement flag is set to tell the CPU that a fresh value can be read. If the 8-bit counter wraps during a measurement, a sticky overflow flag is set. Each flag has its own interrupt enable, and both are cleared through single-cycle strobes. The input is synchronized with two flops before any edge is detected. The first edge after the block is enabled, or after the mode changes, only starts a measurement.

Top module: `span_capture`

## Requirements
- R1: After synchronous reset, `cap_value` is 0, `eom_flag` and `ovf_flag` are 0 and `irq` is 0.
- R2: With `mode` = 0 (rising-edge period), `cap_value` receives the number of `tick`-high cycles strictly between two consecutive detected rising edges. With `tick` held high, a period of P clocks captures P-1.
- R3: With `mode` = 1 (falling-edge period), the same rule applies between consecutive falling edges.
- R4: With `mode` = 2 (high width), counting is gated to cycles where the synchronized input is high. A rising edge starts the pulse and the falling edge captures it. A high pulse of H clocks with `tick` high captures H-1.
- R5: With `mode` = 3 (low width), a falling edge starts the pulse and the rising edge captures it. A low pulse of L clocks captures L-1.
- R6: Cycles in which `tick` is low are not counted.
- R7: The first edge after `enable` rises or `mode` changes only arms the measurement. An end edge with no prior start edge in pulse mode captures nothing and sets no flag.
- R8: `cap_value` holds its value until the next completed measurement. While `enable` is low, input edges produce no capture and no flag.
- R9: The counter is 8 bits wide. A tick while the count is 255 wraps it to 0 and sets `ovf_flag`, so a rising-edge period of 300 clocks captures 43 and sets the flag.
- R10: `eom_flag` is set in the same cycle the capture register loads. It stays set until `eom_clr` is pulsed, and a new capture in the clearing cycle wins over the clear.
- R11: `ovf_flag` stays set until `ovf_clr` is pulsed.
- R12: `irq` is high exactly when (`eom_flag` and `eom_ie`) or (`ovf_flag` and `ovf_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Measurement enable; low stops and disarms |
| mode | input | 2 | 0 rising period, 1 falling period, 2 high width, 3 low width |
| tick | input | 1 | Count enable from the selected clock source |
| sig_in | input | 1 | Asynchronous input being measured |
| eom_ie | input | 1 | Interrupt enable for end of measurement |
| ovf_ie | input | 1 | Interrupt enable for overflow |
| eom_clr | input | 1 | One-cycle strobe clearing the end-of-measurement flag |
| ovf_clr | input | 1 | One-cycle strobe clearing the overflow flag |
| cap_value | output | 8 | Most recent captured measurement |
| eom_flag | output | 1 | Sticky end-of-measurement flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded assertions check on every cycle the following properties:
- The capture register moves only on a measurement event.
- The counter restarts after each capture or wrap.
- A flag set always wins over its clear.
- The interrupt never rises without a pending flag.

Only the bench scenarios can show these behaviours:
- The captured values in each of the four modes match the edge spacing.
- Gated ticks are excluded.
- The arming edge after a mode change or re-enable gives no capture.
- A long period wraps to the expected residue and raises the overflow flag.

// File: rtl/span_pkg.sv
// Package: shared mode encoding for the period / pulse-width capture timer.
// Assumes: the mode values are fixed by the block's port contract.
package span_pkg;
    typedef enum logic [1:0] {
        MODE_PER_RISE = 2'd0,
        MODE_PER_FALL = 2'd1,
        MODE_WID_HIGH = 2'd2,
        MODE_WID_LOW  = 2'd3
    } span_mode_e;
endpackage

// File: rtl/span_sync.sv
// Module: span_sync
// Synchronizes an asynchronous input through STAGES flops and reports the
// synchronized level together with one-cycle rise and fall indications.
// Assumes: the input may change at any time; STAGES is at least 2.
module span_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    // Shift the raw input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[PIPE_W-2:0], sig_in};
    end

    // Derive level and edges from the last synchronized stage and its history.
    always_comb begin
        lvl  = pipe_q[STAGES-1];
        rise =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
        fall = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
    end

    // R7: an edge is always reported against the previous synchronized level
    edge_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/span_counter.sv
// Module: span_counter
// Gated tick counter with edge-selected start/end, capture register and
// one-cycle end-of-measurement and overflow events.
// Assumes: rise/fall/lvl come from a synchronizer in this clock domain.
module span_counter
    import span_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic             tick,
    input  logic             lvl,
    input  logic             rise,
    input  logic             fall,
    output logic [CNT_W-1:0] cap,
    output logic             eom_evt,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    span_mode_e       mode_q;
    logic [CNT_W-1:0] count_q;
    logic             armed_q;
    logic             start_edge;
    logic             end_edge;
    logic             gate;
    logic             active;
    logic             step;

    // Select start edge, end edge and count gate for the current mode.
    always_comb begin
        case (span_mode_e'(mode))
            MODE_PER_RISE: begin start_edge = rise; end_edge = rise; gate = 1'b1; end
            MODE_PER_FALL: begin start_edge = fall; end_edge = fall; gate = 1'b1; end
            MODE_WID_HIGH: begin start_edge = rise; end_edge = fall; gate = lvl;  end
            default:       begin start_edge = fall; end_edge = rise; gate = ~lvl; end
        endcase
    end

    // Decide whether this cycle captures, counts or wraps.
    always_comb begin
        active  = enable && (span_mode_e'(mode) == mode_q);
        eom_evt = active && armed_q && end_edge;
        step    = active && armed_q && gate && tick && !start_edge && !end_edge;
        ovf_evt = step && (count_q == CNT_MAX);
    end

    // Remember the mode so a change can disarm the measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_PER_RISE;
        else        mode_q <= span_mode_e'(mode);
    end

    // Run the counter and arming state; capture before restarting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            armed_q <= 1'b0;
            cap     <= '0;
        end else if (!active) begin
            count_q <= '0;
            armed_q <= 1'b0;
        end else begin
            if (eom_evt)                     cap     <= count_q;
            if (start_edge)                  armed_q <= 1'b1;
            if (start_edge || end_edge)      count_q <= '0;
            else if (step)                   count_q <= count_q + 1'b1;
        end
    end

    // R8
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eom_evt |=> $stable(cap));
    // R2
    restart_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eom_evt |=> (count_q == '0));
    // R9
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (count_q == '0));
    // R8
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !eom_evt && !ovf_evt);
endmodule

// File: rtl/span_flags.sv
// Module: span_flags
// Sticky end-of-measurement and overflow flags with clear strobes and a
// masked, combined interrupt output.
// Assumes: set and clear inputs are one-cycle pulses; set has priority.
module span_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic eom_set,
    input  logic ovf_set,
    input  logic eom_clr,
    input  logic ovf_clr,
    input  logic eom_ie,
    input  logic ovf_ie,
    output logic eom_flag,
    output logic ovf_flag,
    output logic irq
);
    // Hold the end-of-measurement flag until cleared; a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       eom_flag <= 1'b0;
        else if (eom_set) eom_flag <= 1'b1;
        else if (eom_clr) eom_flag <= 1'b0;
    end

    // Hold the overflow flag until cleared; a new wrap wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (ovf_set) ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

    // Combine each flag with its enable into one request.
    always_comb irq = (eom_flag && eom_ie) || (ovf_flag && ovf_ie);

    // R10
    eom_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eom_set |=> eom_flag);
    // R10
    eom_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eom_clr && !eom_set) |=> !eom_flag);
    // R11
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !ovf_set) |=> !ovf_flag);
    // R12
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (eom_flag || ovf_flag));
endmodule

// File: rtl/span_capture.sv
// Module: span_capture (top)
// Period and pulse-width capture timer: synchronizes one input, measures the
// selected span in gated ticks, captures it and raises sticky flags.
// Assumes: tick is already a single-cycle enable in the clk domain.
module span_capture #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic             tick,
    input  logic             sig_in,
    input  logic             eom_ie,
    input  logic             ovf_ie,
    input  logic             eom_clr,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             eom_flag,
    output logic             ovf_flag,
    output logic             irq
);
    logic lvl;
    logic rise;
    logic fall;
    logic eom_evt;
    logic ovf_evt;

    span_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .lvl    (lvl),
        .rise   (rise),
        .fall   (fall)
    );

    span_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode    (mode),
        .tick    (tick),
        .lvl     (lvl),
        .rise    (rise),
        .fall    (fall),
        .cap     (cap_value),
        .eom_evt (eom_evt),
        .ovf_evt (ovf_evt)
    );

    span_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .eom_set  (eom_evt),
        .ovf_set  (ovf_evt),
        .eom_clr  (eom_clr),
        .ovf_clr  (ovf_clr),
        .eom_ie   (eom_ie),
        .ovf_ie   (ovf_ie),
        .eom_flag (eom_flag),
        .ovf_flag (ovf_flag),
        .irq      (irq)
    );
endmodule

// File: tb/span_capture_test.sv
// Scoreboard bench: the driver pushes each expected capture before it shapes
// the input; a monitor pops and compares whenever eom_flag appears.
module span_capture_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       tick = 1'b1;
    logic       sig_in = 1'b0;
    logic       eom_ie = 1'b0;
    logic       ovf_ie = 1'b0;
    logic       eom_clr = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] cap_value;
    logic       eom_flag;
    logic       ovf_flag;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_q[$];
    int cycles = 0;

    span_capture uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .tick(tick),
        .sig_in(sig_in), .eom_ie(eom_ie), .ovf_ie(ovf_ie), .eom_clr(eom_clr),
        .ovf_clr(ovf_clr), .cap_value(cap_value), .eom_flag(eom_flag),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        sig_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: compare each capture, check the interrupt, then clear the flag.
    always @(negedge clk) begin
        if (rst_n) begin
            if (eom_clr) begin
                eom_clr = 1'b0;
                check(!eom_flag, "R10 flag clear", int'(eom_flag), 0);
            end else if (eom_flag) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected capture", int'(cap_value), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(cap_value) == e, "R2-R6 capture value", int'(cap_value), e);
                end
                check(irq == (eom_ie | (ovf_flag & ovf_ie)), "R12 irq on eom",
                      int'(irq), int'(eom_ie | (ovf_flag & ovf_ie)));
                eom_clr = 1'b1;
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                check(1'b0, "watchdog", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cap_value == 8'd0, "R1 cap", int'(cap_value), 0);
        check(!eom_flag && !ovf_flag, "R1 flags", int'({eom_flag, ovf_flag}), 0);
        check(!irq, "R1 irq", int'(irq), 0);

        // R2 rising-edge period: periods 12 and 20 -> 11, 19
        enable = 1'b1; mode = 2'd0;
        hold(0, 8);
        exp_q.push_back(11);
        exp_q.push_back(19);
        hold(1, 6); hold(0, 6); hold(1, 8); hold(0, 12); hold(1, 6);

        // R3 falling-edge period: period 14 -> 13
        mode = 2'd1;
        hold(1, 6);
        exp_q.push_back(13);
        hold(0, 5); hold(1, 9); hold(0, 5); hold(1, 6);

        // R4 high width, R7 unarmed fall ignored: highs 7 and 3 -> 6, 2
        mode = 2'd2; eom_ie = 1'b1;
        hold(1, 6);
        hold(0, 5);
        check(!eom_flag && cap_value == 8'd13, "R7 end edge unarmed", int'(cap_value), 13);
        exp_q.push_back(6);
        exp_q.push_back(2);
        hold(1, 7); hold(0, 5); hold(1, 3); hold(0, 6);

        // R5 low width: lows 9 and 4 -> 8, 3
        mode = 2'd3;
        hold(0, 6);
        hold(1, 4);
        exp_q.push_back(8);
        exp_q.push_back(3);
        hold(0, 9); hold(1, 4); hold(0, 4); hold(1, 6);

        // R6 tick gating in high-width mode: 4 ticks inside a 10-cycle pulse
        mode = 2'd2;
        hold(1, 6);
        hold(0, 6);
        exp_q.push_back(4);
        tick = 1'b0;
        hold(1, 4);
        tick = 1'b1; repeat (4) @(negedge clk);
        tick = 1'b0; repeat (2) @(negedge clk);
        hold(0, 4);
        tick = 1'b1;
        hold(0, 4);
        check(exp_q.size() == 0, "R6 gated capture seen", exp_q.size(), 0);
        check(!ovf_flag, "R9 no early overflow", int'(ovf_flag), 0);

        // R9 overflow: rising period of 300 -> 43, overflow flag set
        mode = 2'd0; ovf_ie = 1'b1; eom_ie = 1'b0;
        hold(0, 6);
        exp_q.push_back(43);
        hold(1, 150); hold(0, 150); hold(1, 8);
        check(ovf_flag, "R9 overflow flag", int'(ovf_flag), 1);
        check(irq, "R12 irq from overflow", int'(irq), 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        check(!ovf_flag, "R11 overflow clear", int'(ovf_flag), 0);
        check(!irq, "R12 irq drops", int'(irq), 0);

        // R8 disabled: edges ignored, capture held
        enable = 1'b0;
        hold(0, 5); hold(1, 5); hold(0, 5); hold(1, 5);
        check(cap_value == 8'd43 && !eom_flag, "R8 disabled hold", int'(cap_value), 43);

        // R7 re-enable: first rise only arms, next period 16 -> 15
        mode = 2'd0; enable = 1'b1;
        hold(0, 6);
        hold(1, 8); hold(0, 8);
        check(cap_value == 8'd43 && !eom_flag, "R7 arming edge", int'(cap_value), 43);
        exp_q.push_back(15);
        hold(1, 6);
        enable = 1'b0;
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R2 all captures seen", exp_q.size(), 0);
        check(cap_value == 8'd15, "R8 capture retained", int'(cap_value), 15);
        finish_run();
    end
endmodule